// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered Converter Code Bank

This block is the digital front end of an eight-channel voltage-output converter. A three-wire serial port (active-low frame select, serial clock, serial data) delivers 16-bit command words, most significant bit first. The bits are taken on falling edges of the serial clock. All pins are sampled by the block's own system clock, so the serial clock must be slower than the system clock. A complete word either writes one channel's staging register or replaces the per-channel power-down mask. A word that is cut short by frame select rising is thrown away.

Each channel holds its code twice. A staging register takes serial writes. An output register drives the converter code. An active-low load strobe moves every staging register that holds unloaded data into its output register, so all outputs can change together. If the strobe is held low, each output follows its staging register one system clock after the write completes. Reset clears all codes and the power-down mask to zero. Resolution is a parameter of 8, 10 or 12 bits. The code field sits left-justified in word bits 11 down to 12-RES, and the bits below it are ignored.

Top module: `dac_bank_front`

## Requirements
- R1: After reset every output code is zero and the power-down mask is zero.
- R2: A data word (bit 15 = 0, bits 14:12 = channel number, code = bits 11 down to 12-RES) completes on the 16th falling serial clock edge while frame select is low. It does not change any output code while the load strobe stays high.
- R3: While the load strobe is low at a system clock edge, every channel holding unloaded data copies its staging register to its output code, one system clock after the strobe is sampled low. All such channels change in the same cycle.
- R4: If frame select rises before the 16th falling edge, the partial word is discarded and no register changes. A later complete frame is received normally.
- R5: With the load strobe held low, an output code takes the new value two system clock edges after the 16th falling serial clock edge is seen.
- R6: A control word (bit 15 = 1) sets the power-down mask to bits 7:0, bit i for channel i, one system clock after its 16th falling edge. It does not depend on the load strobe and leaves all codes untouched.
- R7: At reduced resolution the word bits below bit 12-RES have no effect on the code.
- R8: Falling serial clock edges after the 16th, within the same frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Active-low reset to zero codes |
| fsel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; bits taken on falling edges |
| sdin | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low load strobe |
| dac_code | output | 8*RES | Output codes, channel c at bits c*RES +: RES |
| pd_mask | output | 8 | Per-channel power-down flags |

## Verification
A wrong bit count or a wrong commit condition writes the wrong channel, or writes after an aborted frame. This shows on dac_code at the next load pulse, or two system clocks after the last falling edge when the strobe is held low. A stuck or lost unloaded-data flag shows as a channel that is missing from an otherwise simultaneous update, or that lags by a cycle in follow mode. An error in the power-down mask path appears on pd_mask one clock after the control word ends. Because that path bypasses the load strobe, its timing is checked with the strobe held high.

// File: rtl/dac_bank_front.sv
module dac_bank_front #(
  parameter int RES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsel_n,
  input  logic             sclk,
  input  logic             sdin,
  input  logic             ld_n,
  output logic [8*RES-1:0] dac_code,
  output logic [7:0]       pd_mask
);
  localparam int NCH   = 8;
  localparam int WBITS = 16;
  localparam int CW    = $clog2(WBITS + 1);
  localparam int MSB   = 11;

  logic                     sclk_q;
  logic [CW-1:0]            cnt;
  logic [WBITS-2:0]         shreg;
  logic [NCH-1:0][RES-1:0]  in_q;
  logic [NCH-1:0][RES-1:0]  dac_q;
  logic [NCH-1:0]           newf;
  logic [NCH-1:0]           pd_q;

  wire              fall   = sclk_q & ~sclk;
  wire              last   = ~fsel_n & fall & (cnt == CW'(WBITS - 1));
  wire [WBITS-1:0]  word   = {shreg, sdin};
  wire              is_ctl = word[WBITS-1];
  wire [2:0]        addr   = word[14:12];
  wire [RES-1:0]    code   = word[MSB -: RES];

  assign dac_code = dac_q;
  assign pd_mask  = pd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= '0;
    else if (fsel_n)                           cnt <= '0;
    else if (fall && cnt != CW'(WBITS))        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                          shreg <= '0;
    else if (!fsel_n && fall && cnt < CW'(WBITS - 1))    shreg <= {shreg[WBITS-3:0], sdin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      newf  <= '0;
      pd_q  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (!ld_n && newf[c]) begin
          dac_q[c] <= in_q[c];
          newf[c]  <= 1'b0;
        end
      end
      if (last && !is_ctl) begin
        in_q[addr] <= code;
        newf[addr] <= 1'b1;
      end
      if (last && is_ctl) pd_q <= word[7:0];
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_q == '0 && pd_q == '0));

  a_r3_code_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> !$past(ld_n));

  a_r4_idle_frame_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_n |=> ($stable(in_q) && $stable(pd_q)));

  a_r6_mask_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> ($past(cnt) == CW'(WBITS - 1) && !$past(fsel_n)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WBITS));
endmodule

// File: tb/sim_dac_bank_front.sv
module sim_dac_bank_front;
  localparam int RES = 10;
  logic clk = 1'b0, rst_n = 1'b0, fsel_n = 1'b1, sclk = 1'b1, sdin = 1'b0, ld_n = 1'b1;
  logic [8*RES-1:0] dac_code;
  logic [7:0] pd_mask;
  int n_chk = 0, n_bad = 0;
  logic [RES-1:0] mdl [8];

  always #5 clk = ~clk;

  dac_bank_front #(.RES(RES)) u0 (.clk(clk), .rst_n(rst_n), .fsel_n(fsel_n), .sclk(sclk),
    .sdin(sdin), .ld_n(ld_n), .dac_code(dac_code), .pd_mask(pd_mask));

  // word, channel, expected code at RES=10 (code = word[11:2])
  localparam logic [28:0] VEC [6] = '{
    {16'h0ABC, 3'd0, 10'h2AF},
    {16'h7FFF, 3'd7, 10'h3FF},
    {16'h3003, 3'd3, 10'h000},
    {16'h1555, 3'd1, 10'h155},
    {16'h5800, 3'd5, 10'h200},
    {16'h2FFC, 3'd2, 10'h3FF}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_codes(input string tag);
    for (int c = 0; c < 8; c++)
      chk(tag, 16'(dac_code[c*RES +: RES]), 16'(mdl[c]));
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdin = w[15-i]; sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      if (i != n-1) repeat (2) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [15:0] w);
    @(negedge clk); fsel_n = 1'b0;
    shift_bits(w, 16);
    repeat (2) @(negedge clk);
    fsel_n = 1'b1; sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_ld;
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) mdl[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_codes("R1 reset codes");
    chk("R1 reset mask", 16'(pd_mask), 16'h0);

    for (int v = 0; v < 6; v++) begin
      frame(VEC[v][28:13]);
      chk_codes("R2 no change before load");
      pulse_ld;
      mdl[VEC[v][12:10]] = VEC[v][9:0];
      chk_codes("R3/R7 after load");
    end

    // R4: abort after 10 bits
    @(negedge clk); fsel_n = 1'b0;
    shift_bits(16'h4123, 10);
    @(negedge clk); fsel_n = 1'b1; sclk = 1'b1;
    @(negedge clk);
    pulse_ld;
    chk_codes("R4 aborted frame discarded");
    frame(16'h4124);
    pulse_ld;
    mdl[4] = 10'h049;
    chk_codes("R4 frame after abort");

    // R3: two pending channels update in the same cycle
    frame(16'h0004);
    frame(16'h6FF8);
    chk_codes("R2 two pending unchanged");
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
    mdl[0] = 10'h001; mdl[6] = 10'h3FE;
    chk_codes("R3 simultaneous update");

    // R6: control word, load strobe high
    @(negedge clk); fsel_n = 1'b0;
    shift_bits(16'h80A5, 16);
    chk("R6 mask before edge", 16'(pd_mask), 16'h0);
    @(negedge clk);
    chk("R6 mask after edge", 16'(pd_mask), 16'h00A5);
    @(negedge clk); fsel_n = 1'b1; sclk = 1'b1;
    @(negedge clk);
    chk_codes("R6 codes untouched");

    // R8: extra falling edges in the frame
    @(negedge clk); fsel_n = 1'b0;
    shift_bits(16'h6123, 16);
    shift_bits(16'hFFFF, 4);
    repeat (2) @(negedge clk); fsel_n = 1'b1; sclk = 1'b1;
    pulse_ld;
    mdl[6] = 10'h048;
    chk_codes("R8 extra edges ignored");
    frame(16'hFF5A);
    chk("R8 mask intact", 16'(pd_mask), 16'h005A);

    // R5: follow mode
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); fsel_n = 1'b0;
    shift_bits(16'h4400, 16);
    @(negedge clk);
    chk_codes("R5 one edge after last fall");
    @(negedge clk);
    mdl[4] = 10'h100;
    chk_codes("R5 two edges after last fall");
    fsel_n = 1'b1; sclk = 1'b1;
    ld_n = 1'b1;

    // R1: reset mid-operation
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 8; c++) mdl[c] = '0;
    chk_codes("R1 reset again");
    chk("R1 mask reset again", 16'(pd_mask), 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule